// File: doc/BRIEF.md
# Lane-Partitioned Packed Integer Adder

This block is a small packed-integer execution unit. It keeps eight 128-bit vector registers and runs one operation per clock on a destination register and a source register. The operation is always in two-operand form: the destination is both the first operand and the place the result goes. The 128-bit word is split into lanes whose width is chosen for each operation. A packed add sums every lane at once, and no carry crosses from one lane into the next. A scalar add works on the lowest lane only. Two half-move operations copy the upper or lower 64 bits of the source into the same half of the destination.

Results are registered. They appear on a completion port one cycle after the operation is issued, and the register file is updated at the end of that cycle. An operation issued in the cycle straight after another one sees the pending result through a bypass path. A fill port writes external data into a register, for example load results coming from elsewhere. A combinational debug port reads any register.

Top module: `simd_lane_adder`

## Requirements
- R1: The register file holds eight 128-bit registers. A fill (`fillEn`=1) writes `fillData` into register `fillIdx` at the clock edge. `dbgData` combinationally shows register `dbgIdx`, so the filled value is visible from the next cycle on.
- R2: `opLane` selects the lane width: 2'b00 gives sixteen 8-bit lanes, 2'b01 gives eight 16-bit lanes, 2'b10 gives four 32-bit lanes, and 2'b11 gives two 64-bit lanes.
- R3: Opcode 2'b00 (packed add) adds every lane of the destination to the matching lane of the source. Each lane wraps modulo 2^width, and no carry passes a lane boundary.
- R4: Opcode 2'b01 (scalar add) computes only the lowest lane of the selected width. All destination bits above that lane keep their previous value.
- R5: Opcode 2'b10 replaces destination bits [63:0] with source bits [63:0]. Opcode 2'b11 replaces destination bits [127:64] with source bits [127:64]. In both cases the other half of the destination is kept.
- R6: The result goes to the destination register (dest = dest op src). The source register is left unchanged, and src equal to dst is allowed.
- R7: `done` is high in exactly the cycle after a cycle with `opValid`=1. In that cycle `doneIdx` and `doneData` carry the destination index and the result. The register file takes the result at the end of that cycle.
- R8: An operation issued in the cycle right after another operation uses that operation's result for any operand that names the register it writes.
- R9: When a pending result and a fill target the same register at the same edge, the pending result is stored and the fill is dropped.
- R10: A synchronous active-high `rst` clears all eight registers and the result register to zero, and holds `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | Issue an operation this cycle |
| opCode | input | 2 | 00 packed add, 01 scalar add, 10 move low half, 11 move high half |
| opDst | input | 3 | Destination index, which is also the first operand |
| opSrc | input | 3 | Source register index |
| opLane | input | 2 | Lane width select |
| fillEn | input | 1 | Write fillData into a register |
| fillIdx | input | 3 | Fill target register |
| fillData | input | 128 | Fill value |
| done | output | 1 | Result valid, one cycle after issue |
| doneIdx | output | 3 | Register written by the result |
| doneData | output | 128 | Result value |
| dbgIdx | input | 3 | Debug read index |
| dbgData | output | 128 | Debug read value |

## Verification
Two situations are hard to reach from the ports. The first is a read of a register whose new value exists only in the result register, not yet in the file. The second is a fill and a pending result colliding on one register. The bench issues operations every cycle with randomly chosen and deliberately chained register indices, so bypass reads happen often. In one set cycle it drives a fill to the register that the previous operation is about to write. Carry-heavy patterns, such as all-ones plus one per lane, are swept across all four lane widths so that every possible lane boundary sees a carry that must be blocked.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  typedef enum logic [1:0] {
    OP_PADD  = 2'b00,
    OP_SADD  = 2'b01,
    OP_MOVLO = 2'b10,
    OP_MOVHI = 2'b11
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;  // compute and register a result this cycle
    logic       commit;   // pending result is written to the file at this edge
    logic       fwdDst;   // first operand comes from the pending result
    logic       fwdSrc;   // second operand comes from the pending result
    opKind_t    kind;
    logic [1:0] lane;
  } ctrlStrb_t;

endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add #(
  parameter int VEC_W      = 128,
  parameter int ELEM_W     = 8,
  parameter int LANE_SEL_W = 2
) (
  input  logic [VEC_W-1:0]      a,
  input  logic [VEC_W-1:0]      b,
  input  logic [LANE_SEL_W-1:0] lane,
  input  logic                  scalar,
  output logic [VEC_W-1:0]      sum
);
  localparam int SLICES = VEC_W / ELEM_W;
  localparam int SW     = $clog2(SLICES) + 1;

  logic [SW-1:0]     laneElems;
  logic [SLICES-1:0] boundary;  // slice starts a new lane: carry-in is cut
  logic [SLICES-1:0] inLow;     // slice belongs to the lowest lane

  assign laneElems = SW'(1) << lane;

  genvar g;
  generate
    for (g = 0; g < SLICES; g++) begin : gSlice
      assign boundary[g] = ((SW'(g) & (laneElems - SW'(1))) == '0);
      assign inLow[g]    = (SW'(g) < laneElems);
    end
  endgenerate

  always_comb begin
    logic             c;
    logic             cin;
    logic [ELEM_W-1:0] s;
    c   = 1'b0;
    cin = 1'b0;
    s   = '0;
    sum = '0;
    for (int i = 0; i < SLICES; i++) begin
      cin = boundary[i] ? 1'b0 : c;
      {c, s} = {1'b0, a[i*ELEM_W +: ELEM_W]} + {1'b0, b[i*ELEM_W +: ELEM_W]}
             + {{ELEM_W{1'b0}}, cin};
      sum[i*ELEM_W +: ELEM_W] = (scalar && !inLow[i]) ? a[i*ELEM_W +: ELEM_W] : s;
    end
  end

endmodule

// File: rtl/simd_add_ctrl.sv
module simd_add_ctrl
  import simd_add_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [IDX_W-1:0] opDst,
  input  logic [IDX_W-1:0] opSrc,
  input  logic [1:0]       opLane,
  output ctrlStrb_t        strb,
  output logic [IDX_W-1:0] pendIdx
);
  logic pendValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      pendIdx   <= '0;
    end else begin
      pendValid <= opValid;
      if (opValid) pendIdx <= opDst;
    end
  end

  always_comb begin
    strb.capture = opValid;
    strb.commit  = pendValid;
    strb.fwdDst  = pendValid && (pendIdx == opDst);
    strb.fwdSrc  = pendValid && (pendIdx == opSrc);
    strb.kind    = opKind_t'(opCode);
    strb.lane    = opLane;
  end

  a_r7_done_follows: assert property (@(posedge clk) disable iff (rst)
    opValid |=> pendValid);
  a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> !pendValid);
  a_r7_done_index: assert property (@(posedge clk) disable iff (rst)
    opValid |=> pendIdx == $past(opDst));

endmodule

// File: rtl/simd_add_dp.sv
module simd_add_dp
  import simd_add_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int REG_COUNT = 8,
  parameter int ELEM_W    = 8,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int HALF     = VEC_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrb_t        strb,
  input  logic [IDX_W-1:0] opDst,
  input  logic [IDX_W-1:0] opSrc,
  input  logic [IDX_W-1:0] pendIdx,
  input  logic             fillEn,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [VEC_W-1:0] fillData,
  input  logic [IDX_W-1:0] dbgIdx,
  output logic [VEC_W-1:0] dbgData,
  output logic [VEC_W-1:0] resData
);
  logic [VEC_W-1:0] regs [REG_COUNT];
  logic [VEC_W-1:0] dstOp, srcOp, laneSum, nextRes;
  logic             fillBlocked;

  assign dstOp = strb.fwdDst ? resData : regs[opDst];
  assign srcOp = strb.fwdSrc ? resData : regs[opSrc];

  simd_lane_add #(.VEC_W(VEC_W), .ELEM_W(ELEM_W), .LANE_SEL_W(2)) u_add (
    .a     (dstOp),
    .b     (srcOp),
    .lane  (strb.lane),
    .scalar(strb.kind == OP_SADD),
    .sum   (laneSum)
  );

  always_comb begin
    unique case (strb.kind)
      OP_MOVLO: nextRes = {dstOp[VEC_W-1:HALF], srcOp[HALF-1:0]};
      OP_MOVHI: nextRes = {srcOp[VEC_W-1:HALF], dstOp[HALF-1:0]};
      default:  nextRes = laneSum;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) resData <= '0;
    else if (strb.capture) resData <= nextRes;
  end

  // a pending result outranks a fill aimed at the same register
  assign fillBlocked = strb.commit && (fillIdx == pendIdx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else begin
      if (fillEn && !fillBlocked) regs[fillIdx] <= fillData;
      if (strb.commit) regs[pendIdx] <= resData;
    end
  end

  assign dbgData = regs[dbgIdx];

  a_r3_low_lane_wraps: assert property (@(posedge clk) disable iff (rst)
    (strb.capture && strb.kind == OP_PADD) |=>
      resData[ELEM_W-1:0] == $past(dstOp[ELEM_W-1:0] + srcOp[ELEM_W-1:0]));
  a_r4_scalar_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    (strb.capture && strb.kind == OP_SADD && strb.lane == 2'b00) |=>
      resData[VEC_W-1:ELEM_W] == $past(dstOp[VEC_W-1:ELEM_W]));
  a_r5_movlo_halves: assert property (@(posedge clk) disable iff (rst)
    (strb.capture && strb.kind == OP_MOVLO) |=>
      (resData[VEC_W-1:HALF] == $past(dstOp[VEC_W-1:HALF])) &&
      (resData[HALF-1:0] == $past(srcOp[HALF-1:0])));
  a_r9_commit_wins: assert property (@(posedge clk) disable iff (rst)
    strb.commit |=> regs[$past(pendIdx)] == $past(resData));

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int REG_COUNT = 8,
  parameter int ELEM_W    = 8,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [IDX_W-1:0] opDst,
  input  logic [IDX_W-1:0] opSrc,
  input  logic [1:0]       opLane,
  input  logic             fillEn,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [VEC_W-1:0] fillData,
  output logic             done,
  output logic [IDX_W-1:0] doneIdx,
  output logic [VEC_W-1:0] doneData,
  input  logic [IDX_W-1:0] dbgIdx,
  output logic [VEC_W-1:0] dbgData
);
  ctrlStrb_t        strb;
  logic [IDX_W-1:0] pendIdx;

  simd_add_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk, .rst, .opValid, .opCode, .opDst, .opSrc, .opLane,
    .strb, .pendIdx
  );

  simd_add_dp #(.VEC_W(VEC_W), .REG_COUNT(REG_COUNT), .ELEM_W(ELEM_W)) u_dp (
    .clk, .rst, .strb, .opDst, .opSrc, .pendIdx,
    .fillEn, .fillIdx, .fillData, .dbgIdx, .dbgData,
    .resData(doneData)
  );

  assign done    = strb.commit;
  assign doneIdx = pendIdx;

endmodule

// File: tb/simd_lane_adder_bench.sv
module simd_lane_adder_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         opValid, fillEn;
  logic [1:0]   opCode, opLane;
  logic [2:0]   opDst, opSrc, fillIdx, dbgIdx, doneIdx;
  logic [127:0] fillData, doneData, dbgData;
  logic         done;

  int checks = 0;
  int errors = 0;

  logic [127:0] model [8];
  bit           expPend = 0;
  int           expIdx;
  logic [127:0] expData;
  string        expTag;

  always #10 clk = ~clk;

  simd_lane_adder u_simd_lane_adder (
    .clk, .rst, .opValid, .opCode, .opDst, .opSrc, .opLane,
    .fillEn, .fillIdx, .fillData, .done, .doneIdx, .doneData,
    .dbgIdx, .dbgData
  );

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // reference: lane arithmetic computed with shifts and masks
  function automatic logic [127:0] refOp(logic [1:0] code, logic [127:0] a,
                                         logic [127:0] b, int lane);
    int w;
    int n;
    logic [127:0] mask;
    logic [127:0] r;
    w = 8 << lane;
    mask = (128'd1 << w) - 128'd1;
    if (code == 2'b10) return {a[127:64], b[63:0]};
    if (code == 2'b11) return {b[127:64], a[63:0]};
    r = (code == 2'b01) ? (a & ~mask) : '0;
    n = (code == 2'b01) ? 1 : 128 / w;
    for (int k = 0; k < n; k++)
      r = r | ((((a >> (k*w)) + (b >> (k*w))) & mask) << (k*w));
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock cycle: check the previous issue, then drive this cycle
  task automatic cyc(bit v, logic [1:0] code, int dst, int src, int lane,
                     string tag, bit fe = 0, int fi = 0, logic [127:0] fd = '0);
    logic [127:0] nr;
    @(negedge clk);
    if (expPend) begin
      check({"R7 done high ", expTag}, {127'd0, done}, 128'd1);
      check({"R7 doneIdx ", expTag}, {125'd0, doneIdx}, 128'(expIdx));
      check(expTag, doneData, expData);
    end else begin
      check("R7 done low when idle", {127'd0, done}, 128'd0);
    end
    opValid = v; opCode = code; opDst = 3'(dst); opSrc = 3'(src); opLane = 2'(lane);
    fillEn = fe; fillIdx = 3'(fi); fillData = fd;
    nr = refOp(code, model[dst], model[src], lane);
    if (fe && !(expPend && fi == expIdx)) model[fi] = fd;
    if (v) model[dst] = nr;
    expPend = v; expIdx = dst; expData = nr; expTag = tag;
  endtask

  task automatic idle();
    cyc(0, 2'b00, 0, 0, 0, "");
  endtask

  task automatic fill(int idx, logic [127:0] d);
    cyc(0, 2'b00, 0, 0, 0, "", 1, idx, d);
  endtask

  task automatic regCheck(int idx, string tag);
    @(negedge clk);
    opValid = 0; fillEn = 0;
    dbgIdx = 3'(idx);
    #1;
    check(tag, dbgData, model[idx]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; opValid = 0; fillEn = 0;
    @(negedge clk);
    @(negedge clk);
    check("R10 done low in reset", {127'd0, done}, 128'd0);
    rst = 0;
    expPend = 0;
    for (int i = 0; i < 8; i++) model[i] = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; opValid = 0; fillEn = 0; opCode = 0; opLane = 0;
    opDst = 0; opSrc = 0; fillIdx = 0; fillData = '0; dbgIdx = 0;
    doReset();
    for (int i = 0; i < 8; i++) regCheck(i, "R10 register zero after reset");

    // R1 fill and debug read
    for (int i = 0; i < 8; i++) fill(i, rnd128());
    idle();
    for (int i = 0; i < 8; i++) regCheck(i, "R1 fill then debug read");

    // R2 R3 packed adds, carry-heavy then random, back-to-back issue
    for (int lane = 0; lane < 4; lane++) begin
      fill(0, {128{1'b1}});
      fill(1, {16{8'h01}});
      fill(2, {2{64'h8000_0001_7FFF_FFFF}});
      idle();
      cyc(1, 2'b00, 0, 1, lane, "R3 packed add carry cut (R2 lane select)");
      cyc(1, 2'b00, 2, 2, lane, "R3 packed add self (R2 lane select)");
      for (int k = 0; k < 12; k++)
        cyc(1, 2'b00, $urandom_range(7), $urandom_range(7), lane,
            "R3 packed add random (R8 chained)");
      idle();
      for (int i = 0; i < 8; i++) regCheck(i, "R3 file after packed adds");
    end

    // R4 scalar adds
    for (int lane = 0; lane < 4; lane++) begin
      fill(3, {128{1'b1}});
      fill(4, rnd128());
      idle();
      cyc(1, 2'b01, 3, 4, lane, "R4 scalar add keeps upper bits");
      cyc(1, 2'b01, 4, 3, lane, "R4 scalar add after scalar (R8)");
      idle();
      regCheck(3, "R4 scalar result in file");
    end

    // R5 half moves
    fill(5, rnd128());
    fill(6, rnd128());
    idle();
    cyc(1, 2'b10, 5, 6, 0, "R5 move low half");
    cyc(1, 2'b11, 6, 5, 3, "R5 move high half after low move (R8)");
    idle();
    regCheck(5, "R5 low move in file");
    regCheck(6, "R5 high move in file");

    // R6 destination overwritten, source untouched
    fill(1, rnd128());
    fill(2, rnd128());
    idle();
    cyc(1, 2'b00, 1, 2, 1, "R6 two-operand add");
    idle();
    regCheck(2, "R6 source unchanged");
    regCheck(1, "R6 destination updated");

    // R8 explicit dependency chain on both operands
    cyc(1, 2'b00, 7, 1, 0, "R8 chain step 1");
    cyc(1, 2'b00, 0, 7, 0, "R8 chain source forwarded");
    cyc(1, 2'b00, 0, 0, 2, "R8 chain dst and src forwarded");
    idle();
    regCheck(0, "R8 chain result in file");

    // R9 fill collides with pending commit
    cyc(1, 2'b00, 3, 4, 0, "R9 op before colliding fill");
    fill(3, 128'h0123_4567_89AB_CDEF_0123_4567_89AB_CDEF);
    idle();
    regCheck(3, "R9 commit wins over fill");
    fill(4, 128'hDEAD);
    idle();
    regCheck(4, "R9 fill without collision");

    // R10 reset mid-run
    fill(2, rnd128());
    cyc(1, 2'b00, 2, 2, 0, "");
    doReset();
    for (int i = 0; i < 8; i++) regCheck(i, "R10 register cleared by reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule